// File: doc/BRIEF.md
# Byte-Serial AES-128 Block Encryptor

This block encrypts 128-bit blocks with AES-128 in electronic codebook mode. It has one 8-bit round data path that serves every round. No key schedule is computed on chip. Before any encryption, the host writes all eleven round keys (176 bytes) into an internal key memory, one byte per write. The host then streams in the sixteen plaintext bytes. As each byte arrives it is combined with the matching byte of round key 0, and the result is stored in a 16-byte state memory.

Once the sixteenth byte has been taken, a controller runs ten rounds over the state. Each round has two parts. In the first, every state byte passes through a computed S-box and is written into a scratch memory at its row-rotated position, which performs SubBytes and ShiftRows together. In the second, the scratch memory is read back one byte at a time. Each run of four bytes forms a column, which is mixed in parallel, serialised again, combined with the round key, and written back to the state memory. The tenth round skips the column mixing.

When the last round has been written back, the block raises a one-cycle done strobe and presents the sixteen ciphertext bytes on sixteen consecutive cycles. It then returns to idle and waits for the next block. Blocks do not influence each other.

Top module: `aes8_encryptor`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done` and `ct_valid` are low.
- R2: A key write taken while idle stores `key_din` at `key_addr`. The byte at address 16*k+i is byte i of round key k, for k = 0..10, and round key 0 is the cipher key.
- R3: Plaintext bytes are taken on cycles where `pt_valid` is high while idle, in the order byte 0 to byte 15. Byte i sits in row i mod 4 and column i div 4. `busy` is high in the cycle after the sixteenth byte is taken.
- R4: `done` is high for exactly one cycle. This happens 360 clock edges after the edge that takes the sixteenth plaintext byte: ten rounds of 36 cycles each.
- R5: `ct_valid` is high for exactly 16 consecutive cycles, the first of them being the `done` cycle. In those cycles `ct_byte` carries ciphertext bytes 0 to 15, in the same byte order as the plaintext, and the ciphertext is the AES-128 encryption of the block.
- R6: While `busy` is high, `pt_valid` and `key_we` have no effect. The block in flight finishes with the same ciphertext and the same timing.
- R7: Each block is encrypted independently. The same plaintext under the same keys gives the same ciphertext on every pass.
- R8: `busy` stays high from the cycle after the sixteenth byte until the last ciphertext byte, and it is low in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| key_we | input | 1 | Round-key byte write strobe |
| key_addr | input | 8 | Round-key byte address, 16*round + byte |
| key_din | input | 8 | Round-key byte value |
| pt_valid | input | 1 | Plaintext byte strobe |
| pt_byte | input | 8 | Plaintext byte |
| busy | output | 1 | High from block start until readout ends |
| done | output | 1 | One-cycle strobe when the ciphertext is ready |
| ct_valid | output | 1 | Ciphertext byte valid |
| ct_byte | output | 8 | Ciphertext byte |

## Verification
The block has a single fixed configuration: eleven round keys, sixteen state bytes and a 36-cycle round. The bench therefore uses exactly the shape it ships with. At that size it exercises the full key-memory depth, including the last round key read in the round without mixing. It covers three published key and plaintext pairs, a repeated block, and stray plaintext and key writes injected in the middle of a run against a key byte that the final round uses. For every block it measures the edge count from the last plaintext byte to `done`.

// File: rtl/aes8_encryptor.sv
module aes8_encryptor (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_addr,
  input  logic [7:0] key_din,
  input  logic       pt_valid,
  input  logic [7:0] pt_byte,
  output logic       busy,
  output logic       done,
  output logic       ct_valid,
  output logic [7:0] ct_byte
);
  localparam int NBYTES = 16;
  localparam int NROUND = 10;
  localparam int KDEPTH = (NROUND + 1) * NBYTES;
  localparam logic [7:0] KLAST = 8'(KDEPTH - 1);
  localparam logic [5:0] RLAST = 6'd35;
  localparam logic [3:0] RFINAL = 4'(NROUND);

  typedef enum logic [1:0] {IDLE, RUN, OUT} st_t;

  st_t        st;
  logic [7:0] kmem [0:KDEPTH-1];
  logic [7:0] smem [0:NBYTES-1];
  logic [7:0] tmem [0:NBYTES-1];
  logic [3:0] idx, rnd;
  logic [5:0] cnt;
  logic [23:0] sp;
  logic [31:0] hold;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] r, sq, v, o;
    r  = 8'h01;
    sq = a;
    for (int i = 1; i < 8; i++) begin
      sq = gmul(sq, sq);
      r  = gmul(r, sq);
    end
    v = r;
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return o ^ 8'h63;
  endfunction

  function automatic logic [7:0] colbyte(input logic [31:0] h, input logic [1:0] j, input logic mix);
    logic [7:0] b [4];
    logic [1:0] j1, j2, j3;
    for (int i = 0; i < 4; i++) b[i] = h[31-8*i -: 8];
    j1 = j + 2'd1;
    j2 = j + 2'd2;
    j3 = j + 2'd3;
    if (!mix) return b[j];
    return xt(b[j]) ^ xt(b[j1]) ^ b[j1] ^ b[j2] ^ b[j3];
  endfunction

  logic       ld_we, sub_we, wb_we, kw_ok;
  logic [3:0] widx, saddr;
  logic [1:0] dcol;
  logic [7:0] kaddr, key_rd, tbyte, sdata;

  assign ld_we  = (st == IDLE) && pt_valid;
  assign sub_we = (st == RUN) && (cnt < 6'd16);
  assign wb_we  = (st == RUN) && (cnt >= 6'd20);
  assign kw_ok  = key_we && (st == IDLE) && (key_addr <= KLAST);
  assign widx   = cnt[3:0] - 4'd4;
  assign dcol   = cnt[3:2] - cnt[1:0];
  assign kaddr  = (st == IDLE) ? {4'd0, idx} : {rnd, widx};
  assign key_rd = kmem[kaddr];
  assign tbyte  = tmem[cnt[3:0]];
  assign saddr  = ld_we ? idx : widx;
  assign sdata  = (ld_we ? pt_byte : colbyte(hold, widx[1:0], rnd != RFINAL)) ^ key_rd;

  assign busy     = (st != IDLE);
  assign ct_valid = (st == OUT);
  assign ct_byte  = smem[idx];

  always_ff @(posedge clk) begin
    if (kw_ok) kmem[key_addr] <= key_din;
    if (ld_we || wb_we) smem[saddr] <= sdata;
    if (sub_we) tmem[{dcol, cnt[1:0]}] <= sbox(smem[cnt[3:0]]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= IDLE;
      idx  <= '0;
      rnd  <= '0;
      cnt  <= '0;
      done <= 1'b0;
      sp   <= '0;
      hold <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (pt_valid) begin
          idx <= idx + 4'd1;
          if (idx == 4'd15) begin
            st  <= RUN;
            rnd <= 4'd1;
            cnt <= '0;
          end
        end
        RUN: begin
          if (cnt >= 6'd16 && cnt < 6'd32) begin
            sp <= {sp[15:0], tbyte};
            if (cnt[1:0] == 2'd3) hold <= {sp, tbyte};
          end
          cnt <= cnt + 6'd1;
          if (cnt == RLAST) begin
            cnt <= '0;
            if (rnd == RFINAL) begin
              st   <= OUT;
              idx  <= '0;
              done <= 1'b1;
            end else begin
              rnd <= rnd + 4'd1;
            end
          end
        end
        OUT: begin
          idx <= idx + 4'd1;
          if (idx == 4'd15) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r3_run_after_last_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && pt_valid && idx == 4'd15) |=> (busy && st == RUN && cnt == 6'd0 && rnd == 4'd1));
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r4_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(st == RUN && rnd == RFINAL && cnt == RLAST));
  a_r5_done_opens_readout: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ct_valid && idx == 4'd0));
  a_r8_idle_after_readout: assert property (@(posedge clk) disable iff (!rst_n)
    (ct_valid && idx == 4'd15) |=> (!busy && !ct_valid));
  a_r6_no_key_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !kw_ok);
endmodule

// File: tb/aes8_encryptor_test.sv
module aes8_encryptor_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       key_we = 1'b0;
  logic [7:0] key_addr = '0;
  logic [7:0] key_din = '0;
  logic       pt_valid = 1'b0;
  logic [7:0] pt_byte = '0;
  logic       busy, done, ct_valid;
  logic [7:0] ct_byte;

  aes8_encryptor uut (
    .clk(clk), .rst_n(rst_n), .key_we(key_we), .key_addr(key_addr), .key_din(key_din),
    .pt_valid(pt_valid), .pt_byte(pt_byte), .busy(busy), .done(done),
    .ct_valid(ct_valid), .ct_byte(ct_byte)
  );

  always #5 clk = ~clk;

  int applied = 0;
  int miscompares = 0;
  int cyc = 0;
  logic [7:0] sb [256];
  logic [7:0] rk [176];
  logic [7:0] exp_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && ct_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected ct byte", {24'd0, ct_byte}, 32'd0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(ct_byte == e, "R5 ciphertext byte", {24'd0, ct_byte}, {24'd0, e});
      end
      if (!busy) check(1'b0, "R8 busy during readout", {31'd0, busy}, 32'd1);
    end
    if (rst_n && done && !ct_valid) check(1'b0, "R5 done without ct_valid", 32'd0, 32'd1);
  end

  task automatic build_sbox();
    logic [7:0] p, q, x;
    p = 8'h01;
    q = 8'h01;
    sb[0] = 8'h63;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b0};
      q = q ^ {q[3:0], 4'b0};
      if (q[7]) q = q ^ 8'h09;
      x = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]} ^ {q[3:0], q[7:4]};
      sb[p] = x ^ 8'h63;
    end while (p != 8'h01);
  endtask

  task automatic load_keys(input logic [127:0] k);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0] rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'd0};
        rc = xtime(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int i = 0; i < 44; i++)
      for (int b = 0; b < 4; b++) rk[4*i+b] = w[i][31-8*b -: 8];
    for (int a = 0; a < 176; a++) begin
      @(negedge clk);
      key_we = 1'b1;
      key_addr = 8'(a);
      key_din = rk[a];
    end
    @(negedge clk);
    key_we = 1'b0;
  endtask

  task automatic run_block(input logic [127:0] pt, input logic [127:0] ct, input bit poke, input string tag);
    int start;
    for (int i = 0; i < 16; i++) exp_q.push_back(ct[127-8*i -: 8]);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      pt_valid = 1'b1;
      pt_byte = pt[127-8*i -: 8];
    end
    @(negedge clk);
    pt_valid = 1'b0;
    start = cyc;
    check(busy == 1'b1, "R3 busy after sixteenth byte", {31'd0, busy}, 32'd1);
    if (poke) begin
      // R6: stray writes while busy; address 163 is byte 3 of round key 10
      for (int n = 0; n < 4; n++) begin
        pt_valid = 1'b1;
        pt_byte = 8'ha5;
        key_we = 1'b1;
        key_addr = 8'd163;
        key_din = 8'hff;
        @(negedge clk);
      end
      pt_valid = 1'b0;
      key_we = 1'b0;
    end
    while (!done) @(negedge clk);
    check(cyc - start == 360, {"R4 done latency ", tag}, 32'(cyc - start), 32'd360);
    @(negedge clk);
    check(done == 1'b0, "R4 done single cycle", {31'd0, done}, 32'd0);
    while (busy) @(negedge clk);
    check(exp_q.size() == 0, {"R5 all bytes out ", tag}, 32'(exp_q.size()), 32'd0);
    check(ct_valid == 1'b0, "R8 idle after readout", {31'd0, ct_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy in reset", {31'd0, busy}, 32'd0);
    check(done == 1'b0, "R1 done in reset", {31'd0, done}, 32'd0);
    check(ct_valid == 1'b0, "R1 ct_valid in reset", {31'd0, ct_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && ct_valid == 1'b0, "R1 after reset",
          {29'd0, busy, done, ct_valid}, 32'd0);

    // R2 keys for the counting-byte cipher key
    load_keys(128'h000102030405060708090a0b0c0d0e0f);
    run_block(128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, "vecA");
    // R7 same block again gives the same result
    run_block(128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0, "vecA repeat");
    // R6 stray plaintext and key writes mid-run
    run_block(128'h00112233445566778899aabbccddeeff, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b1, "vecA poked");
    // R2 reload with another key
    load_keys(128'h2b7e151628aed2a6abf7158809cf4f3c);
    run_block(128'h3243f6a8885a308d313198a2e0370734, 128'h3925841d02dc09fbdc118597196a0b32, 1'b0, "vecB");
    load_keys(128'h0);
    run_block(128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b0, "zero");

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule